// File: doc/BRIEF.md
# External Trigger Start Detector

This block lets a pin outside the chip start conversion sequences of an analog-to-digital converter. The raw pin is first brought into the bus clock domain through a chain of flip-flops. The synchronised level is then qualified by one of four sensitivities, chosen by a two-bit code: a rising edge, a falling edge, a high level or a low level. A qualified event while the sequencer is idle becomes a start request to the sequencer.

In edge mode, the block records an active edge that arrives while a sequence is still running in a sticky overrun flag, because such an edge is lost. Software clears the flag in one of three ways: by writing one to it, by a configuration write that aborts the running sequence, or by starting a fresh sequence. When trigger mode is off, no start is requested and the flag is not set. While trigger mode is on, the pin is reserved for triggering, and its converted results are not meaningful. The sequencer is outside this block. All its pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `xtrig_detect`

## Requirements
- R1: With mode code {trig_level, trig_pol} = 00 (falling edge) or 01 (rising edge), an active edge on the synchronised pin while seq_busy is 0 gives a start_req pulse exactly one clock long. An edge of the opposite direction gives no start.
- R2: With mode code 10 (low level) or 11 (high level), start_req stays high in every cycle in which the synchronised pin is at the active level and seq_busy is 0. It is low otherwise.
- R3: start_req is never high in a cycle in which seq_busy is 1.
- R4: In edge mode, an active edge seen while seq_busy is 1 sets overrun in the next cycle. In level mode, overrun is never set.
- R5: overrun is sticky. It is cleared in the cycle after any one of ovr_clr, cfg_abort or sw_start is high.
- R6: When an overrun-setting edge and a clear event fall in the same cycle, the set wins and overrun reads 1 afterwards.
- R7: While trig_en is 0, start_req stays 0 and overrun is not set. An existing overrun value is kept unless a clear event arrives.
- R8: A pin change reaches start_req after exactly SYNC_STAGES rising clock edges (2 by default). After one edge there is no effect yet.
- R9: After reset, start_req and overrun are both 0.
- R10: Turning trig_en on while the pin already sits at the level that follows an active edge produces no start, because the edge history keeps tracking while the detector is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_pin | input | 1 | Raw external trigger pin, asynchronous |
| trig_en | input | 1 | Trigger mode enable (resets to 0 in the register that drives it) |
| trig_level | input | 1 | 1 = level sensitive, 0 = edge sensitive |
| trig_pol | input | 1 | 1 = high/rising active, 0 = low/falling active |
| seq_busy | input | 1 | Sequencer is running a conversion sequence |
| ovr_clr | input | 1 | Software write of one to the overrun flag |
| cfg_abort | input | 1 | Configuration write that aborts the sequence |
| sw_start | input | 1 | Software start of a new sequence |
| start_req | output | 1 | Start request to the sequencer |
| overrun | output | 1 | Sticky trigger overrun flag |

## Verification
The overrun flag can be set by a lost edge and cleared by a software event in the same clock cycle. The bench provokes this collision by holding seq_busy high and raising the pin so that the synchronised edge lands in the cycle in which ovr_clr is pulsed. It then judges that overrun reads 1 in the following cycle, and that a lone clear afterwards drops it. A second collision is a level-mode active level during a busy sequence. The bench checks that this is neither a start nor an overrun.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;

  // Sensitivity code formed as {level_select, polarity}
  typedef enum logic [1:0] {
    TRG_FALL = 2'b00,
    TRG_RISE = 2'b01,
    TRG_LOW  = 2'b10,
    TRG_HIGH = 2'b11
  } trg_mode_e;

  function automatic logic mode_is_level(trg_mode_e m);
    return m[1];
  endfunction

  function automatic logic mode_active_high(trg_mode_e m);
    return m[0];
  endfunction

endpackage

// File: rtl/xtrig_sync.sv
module xtrig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    genvar gi;
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[gi] <= 1'b0;
          else        chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[LAST];

endmodule

// File: rtl/xtrig_qualify.sv
module xtrig_qualify
  import xtrig_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_sync,
  input  trg_mode_e mode,
  output logic      edge_hit,
  output logic      level_hit
);

  logic pin_prev;
  logic rose;
  logic fell;

  // History always tracks, so enabling later never sees a stale edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev <= 1'b0;
    else        pin_prev <= pin_sync;
  end

  assign rose = pin_sync & ~pin_prev;
  assign fell = ~pin_sync & pin_prev;

  always_comb begin
    edge_hit  = 1'b0;
    level_hit = 1'b0;
    unique case (mode)
      TRG_FALL: edge_hit  = fell;
      TRG_RISE: edge_hit  = rose;
      TRG_LOW:  level_hit = ~pin_sync;
      TRG_HIGH: level_hit = pin_sync;
      default:  edge_hit  = 1'b0;
    endcase
  end

endmodule

// File: rtl/xtrig_overrun.sv
module xtrig_overrun (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  // A lost edge outranks a clear arriving in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

endmodule

// File: rtl/xtrig_detect.sv
module xtrig_detect
  import xtrig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_pin,
  input  logic trig_en,
  input  logic trig_level,
  input  logic trig_pol,
  input  logic seq_busy,
  input  logic ovr_clr,
  input  logic cfg_abort,
  input  logic sw_start,
  output logic start_req,
  output logic overrun
);

  trg_mode_e mode;
  logic      pin_s;
  logic      edge_hit;
  logic      level_hit;
  logic      event_hit;
  logic      lost_edge;
  logic      any_clr;

  assign mode = trg_mode_e'({trig_level, trig_pol});

  xtrig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (trig_pin),
    .q_sync  (pin_s)
  );

  xtrig_qualify u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_sync  (pin_s),
    .mode      (mode),
    .edge_hit  (edge_hit),
    .level_hit (level_hit)
  );

  assign event_hit = mode_is_level(mode) ? level_hit : edge_hit;
  assign start_req = trig_en & ~seq_busy & event_hit;
  assign lost_edge = trig_en & seq_busy & edge_hit;
  assign any_clr   = ovr_clr | cfg_abort | sw_start;

  xtrig_overrun u_ovr (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (lost_edge),
    .clr_i  (any_clr),
    .flag_o (overrun)
  );

endmodule

// File: rtl/xtrig_detect_chk.sv
module xtrig_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic trig_en,
  input logic trig_level,
  input logic seq_busy,
  input logic ovr_clr,
  input logic cfg_abort,
  input logic sw_start,
  input logic start_req,
  input logic overrun
);

  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> !start_req); // R3

  AST_EDGE_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !trig_level && !seq_busy) |=> !start_req || trig_level); // R1

  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_en |-> !start_req); // R7

  AST_OVR_HELD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_en && !ovr_clr && !cfg_abort && !sw_start) |=> $stable(overrun)); // R7

  AST_OVR_ONLY_EDGE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_level && !overrun) |=> !overrun); // R4

  AST_OVR_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!overrun && !(seq_busy && trig_en)) |=> !overrun); // R4

  AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovr_clr || cfg_abort || sw_start) && !seq_busy) |=> !overrun); // R5

endmodule

bind xtrig_detect xtrig_detect_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trig_en    (trig_en),
  .trig_level (trig_level),
  .seq_busy   (seq_busy),
  .ovr_clr    (ovr_clr),
  .cfg_abort  (cfg_abort),
  .sw_start   (sw_start),
  .start_req  (start_req),
  .overrun    (overrun)
);

// File: tb/xtrig_detect_tb.sv
module xtrig_detect_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_pin = 1'b0;
  logic trig_en = 1'b0;
  logic trig_level = 1'b0;
  logic trig_pol = 1'b0;
  logic seq_busy = 1'b0;
  logic ovr_clr = 1'b0;
  logic cfg_abort = 1'b0;
  logic sw_start = 1'b0;
  logic start_req;
  logic overrun;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xtrig_detect u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_pin   (trig_pin),
    .trig_en    (trig_en),
    .trig_level (trig_level),
    .trig_pol   (trig_pol),
    .seq_busy   (seq_busy),
    .ovr_clr    (ovr_clr),
    .cfg_abort  (cfg_abort),
    .sw_start   (sw_start),
    .start_req  (start_req),
    .overrun    (overrun)
  );

  // {level, pol, pin_from, pin_to, busy, exp_start_window, exp_start_after, exp_ovr}
  localparam logic [7:0] VEC [10] = '{
    8'b0_1_0_1_0_1_0_0,  // R1 rising edge idle
    8'b0_1_1_0_0_0_0_0,  // R1 falling edge ignored in rise mode
    8'b0_0_1_0_0_1_0_0,  // R1 falling edge idle
    8'b0_0_0_1_0_0_0_0,  // R1 rising edge ignored in fall mode
    8'b0_1_0_1_1_0_0_1,  // R4 rising edge lost while busy
    8'b0_0_1_0_1_0_0_1,  // R4 falling edge lost while busy
    8'b1_1_0_1_0_1_1_0,  // R2 high level held
    8'b1_0_1_0_0_1_1_0,  // R2 low level held
    8'b1_1_0_1_1_0_0_0,  // R3 R4 high level while busy
    8'b1_0_0_1_0_0_0_0   // R2 low mode, pin leaves active level
  };

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    ovr_clr = 1'b1;
    cyc(1);
    ovr_clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    check("R9 start after reset", start_req, 1'b0);
    check("R9 overrun after reset", overrun, 1'b0);
    rst_n = 1'b1;
    cyc(2);
    check("R9 start idle", start_req, 1'b0);
    check("R9 overrun idle", overrun, 1'b0);

    trig_en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      logic [7:0] v;
      v = VEC[i];
      seq_busy = 1'b0;
      trig_level = 1'b0;
      trig_pol = 1'b1;
      trig_pin = v[5];
      cyc(4);
      pulse_clr();
      trig_level = v[7];
      trig_pol = v[6];
      seq_busy = v[3];
      cyc(1);
      trig_pin = v[4];
      cyc(2);
      check($sformatf("R1/R2/R3 vec %0d start window", i), start_req, v[2]);
      cyc(1);
      check($sformatf("R1/R2 vec %0d start after", i), start_req, v[1]);
      check($sformatf("R4 vec %0d overrun", i), overrun, v[0]);
    end

    // R8: synchroniser latency
    seq_busy = 1'b0; trig_level = 1'b0; trig_pol = 1'b1; trig_pin = 1'b0;
    cyc(4);
    trig_pin = 1'b1;
    cyc(1);
    check("R8 no start after one edge", start_req, 1'b0);
    cyc(1);
    check("R8 start after two edges", start_req, 1'b1);

    // R5: each clear source on its own
    trig_pin = 1'b0; seq_busy = 1'b1; cyc(4);
    trig_pin = 1'b1; cyc(3);
    check("R4 overrun set for R5 test", overrun, 1'b1);
    seq_busy = 1'b0;
    cyc(2);
    check("R5 overrun sticky", overrun, 1'b1);
    cfg_abort = 1'b1; cyc(1); cfg_abort = 1'b0;
    check("R5 cleared by cfg_abort", overrun, 1'b0);
    trig_pin = 1'b0; seq_busy = 1'b1; cyc(4);
    trig_pin = 1'b1; cyc(3);
    sw_start = 1'b1; cyc(1); sw_start = 1'b0;
    check("R5 cleared by sw_start", overrun, 1'b0);

    // R6: set and clear in the same cycle
    trig_pin = 1'b0; cyc(4);
    trig_pin = 1'b1; cyc(2);
    ovr_clr = 1'b1;
    check("R3 no start while busy", start_req, 1'b0);
    cyc(1);
    ovr_clr = 1'b0;
    check("R6 set wins over clear", overrun, 1'b1);
    pulse_clr();
    check("R5 cleared by ovr_clr", overrun, 1'b0);

    // R7: disabled detector, overrun held at 1
    trig_pin = 1'b0; cyc(4);
    trig_pin = 1'b1; cyc(3);
    trig_en = 1'b0;
    trig_pin = 1'b0; cyc(4);
    trig_pin = 1'b1; cyc(2);
    check("R7 no start when disabled", start_req, 1'b0);
    cyc(1);
    check("R7 overrun held when disabled", overrun, 1'b1);
    seq_busy = 1'b0;
    trig_pin = 1'b0; cyc(4);
    trig_pin = 1'b1; cyc(2);
    check("R7 no start disabled idle", start_req, 1'b0);
    trig_level = 1'b1; cyc(1);
    check("R7 no level start disabled", start_req, 1'b0);
    pulse_clr();

    // R10: enable with pin already past the edge
    trig_level = 1'b0; trig_pol = 1'b1; cyc(3);
    trig_en = 1'b1;
    check("R10 no start on enable", start_req, 1'b0);
    cyc(1);
    check("R10 no start cycle after enable", start_req, 1'b0);

    // R9: reset mid-activity
    trig_level = 1'b1; cyc(1);
    check("R2 high level start", start_req, 1'b1);
    rst_n = 1'b0; cyc(1);
    check("R9 start during reset", start_req, 1'b0);
    check("R9 overrun during reset", overrun, 1'b0);
    rst_n = 1'b1;
    cyc(2);

    finish_run();
  end

endmodule